// File: doc/BRIEF.md
# Aliasing-Aware Instruction-Cache Line Invalidate Sequencer

This block turns one invalidate request, a byte range given as a start address and a byte count, into a stream of per-line invalidate commands for an instruction cache that is indexed by virtual address and tagged by physical address. It rounds the range out to whole cache lines. The range is end-exclusive, so it never reaches past its last byte. For every line it issues enough commands to reach each set in which that line could sit. The number of such sets comes from the configured ratio of way size to page size.

Two command styles are supported. In the packed style, each line gets one invalidate per alias. The alias selector is carried in the otherwise unused low offset bits of the command address. In the split style, each line first writes its physical address as a tag command. Then one invalidate per alias follows, with the page-number bits just above the page offset forced to the alias value. When the caller also supplies the virtual address, alias enumeration is skipped and one invalidate per line is issued. In the packed style, that invalidate carries five virtual page bits in the low address bits. In the split style, it carries the line-aligned virtual address, which steps by one line per line.

Requests enter through a valid/ready pair. `req_ready` is high only while the sequencer is idle. Commands leave through a second valid/ready pair. A command, once offered, stays fixed until `cmd_ready` takes it, and the sequencer may be stalled for any number of cycles. `done` pulses for one cycle when a request is finished.

Top module: `icinv_invalidate_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and both `cmd_valid` and `done` are 0.
- R2: The first line is the start address rounded down to a line boundary. The line count is (size + removed offset) divided by the line length, rounded up. Consecutive lines step by the line length, and a range ending exactly on a line boundary does not touch the following line.
- R3: A request of size 0 with a supported ratio produces no command. `done` is high in the cycle after the request is accepted, and `cfg_err` stays 0.
- R4: A `cfg_ratio` other than 0, 1, 2 or 4 produces no command. `done` and `cfg_err` are both high in the cycle after acceptance.
- R5: Packed style (`cfg_tag_mode`=0) without a virtual address: each line gets invalidates with command address = line address OR k. Here k runs 0 to N-1, with N=1 for ratio 0 or 1, N=2 for ratio 2 and N=4 for ratio 4.
- R6: Packed style with a virtual address (`req_has_va`=1): each line gets exactly one invalidate, with command address = line address OR virtual bits [PAGE_SHIFT+4:PAGE_SHIFT] placed in bits [4:0].
- R7: Split style (`cfg_tag_mode`=1) without a virtual address: each line gives a tag command (`cmd_is_tag`=1, address = line address). This is followed by N invalidates (`cmd_is_tag`=0). Invalidate k has bit PAGE_SHIFT equal to k for N=2, has bits [PAGE_SHIFT+1:PAGE_SHIFT] equal to k for N=4, and is the unchanged line address for N=1.
- R8: Split style with a virtual address: each line gives a tag command with the physical line address and one invalidate with the line-aligned virtual address. Both advance by the line length per line.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_is_tag` and `cmd_addr` are held unchanged in the next cycle.
- R10: `done` pulses for exactly one cycle, in the cycle after the final command is accepted. `done` and `cmd_valid` are never high together, and `req_ready` is 0 from acceptance until after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; request accepted when both are high |
| req_start | input | AW | Physical start byte address |
| req_size | input | SW | Byte count of the range |
| req_has_va | input | 1 | Virtual address supplied; skip alias enumeration |
| req_vaddr | input | AW | Virtual start address, used when `req_has_va` is 1 |
| cfg_tag_mode | input | 1 | 0 packed style, 1 split tag/invalidate style |
| cfg_ratio | input | 3 | Way-size to page-size ratio |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Cache control port accepts the command |
| cmd_is_tag | output | 1 | 1 tag-register write, 0 line invalidate |
| cmd_addr | output | AW | Command address |
| done | output | 1 | One-cycle pulse when the request is finished |
| cfg_err | output | 1 | Pulses with `done` when the ratio was unsupported |

## Verification
The checker watches every cycle for the following:
- commands staying frozen under back-pressure;
- `done` being a single pulse that never overlaps a command;
- `cfg_err` appearing only with `done`;
- a tag command always being followed by an invalidate;
- tag addresses being line-aligned;
- the immediate completion of zero-size and bad-ratio requests.

The actual address sequence can only be shown by the scoreboard scenarios, because it depends on the whole request. That sequence covers the line rounding, the end-exclusive count, the alias values for each ratio and style, and the packing of virtual bits. The same holds for the exact cycle in which `done` follows the last accepted command.

// File: rtl/icinv_pkg.sv
package icinv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAG  = 2'd1,
    ST_INV  = 2'd2,
    ST_FIN  = 2'd3
  } icinv_state_e;

  // number of virtual page bits packed into the low command bits
  localparam int unsigned PACK_W = 5;
  // maximum alias count is 4, selector is 2 bits
  localparam int unsigned ALIAS_W = 2;
endpackage

// File: rtl/icinv_range_calc.sv
module icinv_range_calc #(
  parameter int unsigned AW         = 32,
  parameter int unsigned SW         = 16,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic [AW-1:0] start_addr,
  input  logic [SW-1:0] byte_cnt,
  output logic [AW-1:0] line_base,
  output logic [SW:0]   line_cnt
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] OFF_MASK = AW'(LINE_BYTES - 1);

  logic [OFF_W-1:0] slack;
  logic [SW+1:0]    span;
  logic [SW+1:0]    rounded;

  always_comb begin
    slack     = start_addr[OFF_W-1:0];
    line_base = start_addr & ~OFF_MASK;
    span      = {2'b00, byte_cnt} + (SW+2)'(slack);
    rounded   = span + (SW+2)'(LINE_BYTES - 1);
    line_cnt  = (SW+1)'(rounded >> OFF_W);
  end
endmodule

// File: rtl/icinv_alias_gen.sv
module icinv_alias_gen #(
  parameter int unsigned AW         = 32,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic                         tag_mode,
  input  logic                         use_va,
  input  logic [AW-1:0]                line_pa,
  input  logic [AW-1:0]                line_va,
  input  logic [icinv_pkg::PACK_W-1:0] va_pack,
  input  logic [icinv_pkg::ALIAS_W-1:0] alias_idx,
  input  logic [icinv_pkg::ALIAS_W-1:0] alias_last,
  output logic [AW-1:0]                inv_addr
);
  logic [AW-1:0] packed_addr;
  logic [AW-1:0] split_addr;

  always_comb begin
    // packed style: selector rides in the line offset bits
    if (use_va) packed_addr = line_pa | AW'(va_pack);
    else        packed_addr = line_pa | AW'(alias_idx);

    // split style: page-number bits above the offset forced to the selector
    if (use_va) split_addr = line_va;
    else        split_addr = (line_pa & ~(AW'(alias_last) << PAGE_SHIFT))
                             | (AW'(alias_idx) << PAGE_SHIFT);

    inv_addr = tag_mode ? split_addr : packed_addr;
  end
endmodule

// File: rtl/icinv_seq_ctrl.sv
module icinv_seq_ctrl #(
  parameter int unsigned AW         = 32,
  parameter int unsigned SW         = 16,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [AW-1:0]                 calc_base,
  input  logic [SW:0]                   calc_lines,
  input  logic                          size_zero,
  input  logic                          req_has_va,
  input  logic [AW-1:0]                 req_vaddr,
  input  logic                          cfg_tag_mode,
  input  logic [2:0]                    cfg_ratio,
  input  logic                          cmd_ready,
  output logic                          cmd_valid,
  output logic                          cmd_is_tag,
  output logic [AW-1:0]                 line_pa,
  output logic [AW-1:0]                 line_va,
  output logic [icinv_pkg::PACK_W-1:0]  va_pack,
  output logic [icinv_pkg::ALIAS_W-1:0] alias_idx,
  output logic [icinv_pkg::ALIAS_W-1:0] alias_last,
  output logic                          tag_mode_q,
  output logic                          use_va_q,
  output logic                          done,
  output logic                          cfg_err
);
  import icinv_pkg::*;

  localparam logic [AW-1:0] OFF_MASK = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] STEP     = AW'(LINE_BYTES);

  icinv_state_e         state;
  logic [SW:0]          lines_left;
  logic                 err_q;
  logic                 ratio_ok;
  logic [ALIAS_W-1:0]   ratio_last;
  logic                 last_alias;

  always_comb begin
    unique case (cfg_ratio)
      3'd0, 3'd1: begin ratio_ok = 1'b1; ratio_last = 2'd0; end
      3'd2:       begin ratio_ok = 1'b1; ratio_last = 2'd1; end
      3'd4:       begin ratio_ok = 1'b1; ratio_last = 2'd3; end
      default:    begin ratio_ok = 1'b0; ratio_last = 2'd0; end
    endcase
    last_alias = (alias_idx == alias_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      line_pa    <= '0;
      line_va    <= '0;
      va_pack    <= '0;
      lines_left <= '0;
      alias_idx  <= '0;
      alias_last <= '0;
      tag_mode_q <= 1'b0;
      use_va_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          line_pa    <= calc_base;
          line_va    <= req_vaddr & ~OFF_MASK;
          va_pack    <= req_vaddr[PAGE_SHIFT +: PACK_W];
          lines_left <= calc_lines;
          alias_idx  <= '0;
          alias_last <= req_has_va ? '0 : ratio_last;
          tag_mode_q <= cfg_tag_mode;
          use_va_q   <= req_has_va;
          err_q      <= !ratio_ok;
          if (!ratio_ok || size_zero) state <= ST_FIN;
          else                        state <= cfg_tag_mode ? ST_TAG : ST_INV;
        end
        ST_TAG: if (cmd_ready) state <= ST_INV;
        ST_INV: if (cmd_ready) begin
          if (last_alias) begin
            alias_idx <= '0;
            if (lines_left == (SW+1)'(1)) begin
              state <= ST_FIN;
            end else begin
              lines_left <= lines_left - (SW+1)'(1);
              line_pa    <= line_pa + STEP;
              line_va    <= line_va + STEP;
              state      <= tag_mode_q ? ST_TAG : ST_INV;
            end
          end else begin
            alias_idx <= alias_idx + 2'd1;
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
          err_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready  = (state == ST_IDLE);
    cmd_valid  = (state == ST_TAG) || (state == ST_INV);
    cmd_is_tag = (state == ST_TAG);
    done       = (state == ST_FIN);
    cfg_err    = (state == ST_FIN) && err_q;
  end
endmodule

// File: rtl/icinv_invalidate_seq.sv
module icinv_invalidate_seq #(
  parameter int unsigned AW         = 32,
  parameter int unsigned SW         = 16,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_start,
  input  logic [SW-1:0] req_size,
  input  logic          req_has_va,
  input  logic [AW-1:0] req_vaddr,
  input  logic          cfg_tag_mode,
  input  logic [2:0]    cfg_ratio,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_is_tag,
  output logic [AW-1:0] cmd_addr,
  output logic          done,
  output logic          cfg_err
);
  import icinv_pkg::*;

  logic [AW-1:0]      calc_base;
  logic [SW:0]        calc_lines;
  logic [AW-1:0]      line_pa;
  logic [AW-1:0]      line_va;
  logic [PACK_W-1:0]  va_pack;
  logic [ALIAS_W-1:0] alias_idx;
  logic [ALIAS_W-1:0] alias_last;
  logic               tag_mode_q;
  logic               use_va_q;
  logic [AW-1:0]      inv_addr;

  icinv_range_calc #(.AW(AW), .SW(SW), .LINE_BYTES(LINE_BYTES)) u_range (
    .start_addr (req_start),
    .byte_cnt   (req_size),
    .line_base  (calc_base),
    .line_cnt   (calc_lines)
  );

  icinv_seq_ctrl #(.AW(AW), .SW(SW), .LINE_BYTES(LINE_BYTES),
                   .PAGE_SHIFT(PAGE_SHIFT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .calc_base    (calc_base),
    .calc_lines   (calc_lines),
    .size_zero    (req_size == '0),
    .req_has_va   (req_has_va),
    .req_vaddr    (req_vaddr),
    .cfg_tag_mode (cfg_tag_mode),
    .cfg_ratio    (cfg_ratio),
    .cmd_ready    (cmd_ready),
    .cmd_valid    (cmd_valid),
    .cmd_is_tag   (cmd_is_tag),
    .line_pa      (line_pa),
    .line_va      (line_va),
    .va_pack      (va_pack),
    .alias_idx    (alias_idx),
    .alias_last   (alias_last),
    .tag_mode_q   (tag_mode_q),
    .use_va_q     (use_va_q),
    .done         (done),
    .cfg_err      (cfg_err)
  );

  icinv_alias_gen #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_alias (
    .tag_mode   (tag_mode_q),
    .use_va     (use_va_q),
    .line_pa    (line_pa),
    .line_va    (line_va),
    .va_pack    (va_pack),
    .alias_idx  (alias_idx),
    .alias_last (alias_last),
    .inv_addr   (inv_addr)
  );

  assign cmd_addr = cmd_is_tag ? line_pa : inv_addr;
endmodule

// File: rtl/icinv_seq_chk.sv
module icinv_seq_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned SW         = 16,
  parameter int unsigned LINE_BYTES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] req_size,
  input logic [2:0]    cfg_ratio,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_is_tag,
  input logic [AW-1:0] cmd_addr,
  input logic          done,
  input logic          cfg_err
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);

  logic ratio_bad;
  logic req_fire;
  assign ratio_bad = !(cfg_ratio == 3'd0 || cfg_ratio == 3'd1 ||
                       cfg_ratio == 3'd2 || cfg_ratio == 3'd4);
  assign req_fire  = req_valid && req_ready;

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_is_tag) && $stable(cmd_addr));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && cmd_valid));

  // R10
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (cmd_valid || done)));

  // R4
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> done);

  // R3
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !ratio_bad && req_size == '0 |=> done && !cmd_valid && !cfg_err);

  // R4
  bad_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && ratio_bad |=> done && cfg_err && !cmd_valid);

  // R7
  tag_then_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_is_tag |=> cmd_valid && !cmd_is_tag);

  // R2
  tag_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_is_tag |-> cmd_addr[OFF_W-1:0] == '0);
endmodule

bind icinv_invalidate_seq icinv_seq_chk #(.AW(AW), .SW(SW), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/tb_icinv_invalidate_seq.sv
module tb_icinv_invalidate_seq;
  localparam int AW = 32;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_start = '0;
  logic [SW-1:0] req_size = '0;
  logic          req_has_va = 1'b0;
  logic [AW-1:0] req_vaddr = '0;
  logic          cfg_tag_mode = 1'b0;
  logic [2:0]    cfg_ratio = 3'd0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic          cmd_is_tag;
  logic [AW-1:0] cmd_addr;
  logic          done;
  logic          cfg_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_fire_cyc = -1;
  int fires = 0;
  bit bp_on = 1'b0;
  bit run_mon = 1'b0;
  logic [AW:0] exp_q[$];

  icinv_invalidate_seq #(.AW(AW), .SW(SW), .LINE_BYTES(32), .PAGE_SHIFT(13)) dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // monitor: drives ready for the coming edge, then compares any handshake
  initial begin
    forever begin
      @(negedge clk);
      cmd_ready = bp_on ? (((cyc * 7) % 5) > 1) : 1'b1;
      #1;
      if (run_mon && cmd_valid && cmd_ready) begin
        logic [AW:0] got;
        got = {cmd_is_tag, cmd_addr};
        fires++;
        last_fire_cyc = cyc + 1;
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected command", got, 0);
        else begin
          logic [AW:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R5-R8 sequence (R5 R6 R7 R8)", "command", got, e);
        end
      end
    end
  end

  task automatic run_req(input logic [31:0] st, input logic [15:0] sz, input bit hv,
                         input logic [31:0] va, input bit tm, input logic [2:0] rt,
                         input string rq);
    bit bad;
    int n, nl, waits;
    logic [31:0] base, vbase;
    bad = !(rt == 0 || rt == 1 || rt == 2 || rt == 4);
    n = (rt == 2) ? 2 : (rt == 4) ? 4 : 1;
    if (hv) n = 1;
    nl = (int'(sz) + int'(st[4:0]) + 31) / 32;
    base = {st[31:5], 5'b0};
    vbase = {va[31:5], 5'b0};
    if (!bad && sz != 0) begin
      for (int l = 0; l < nl; l++) begin
        logic [31:0] lp, lv;
        lp = base + 32'(l * 32);
        lv = vbase + 32'(l * 32);
        if (tm) exp_q.push_back({1'b1, lp});
        for (int a = 0; a < n; a++) begin
          logic [31:0] e;
          if (!tm) e = hv ? (lp | {27'b0, va[17:13]}) : (lp | 32'(a));
          else if (hv) e = lv;
          else begin
            e = lp;
            if (n == 2) e[13] = a[0];
            if (n == 4) e[14:13] = a[1:0];
          end
          exp_q.push_back({1'b0, e});
        end
      end
    end
    fires = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    req_start = st; req_size = sz; req_has_va = hv; req_vaddr = va;
    cfg_tag_mode = tm; cfg_ratio = rt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waits = 0;
    while (!done && waits < 2000) begin
      @(negedge clk);
      waits++;
    end
    chk(done == 1'b1, rq, "done seen", done, 1);
    chk(cfg_err == bad, bad ? "R4" : rq, "cfg_err", cfg_err, bad);
    chk(exp_q.size() == 0, "R2", "missing commands", exp_q.size(), 0);
    if (bad || sz == 0) begin
      chk(waits == 0, bad ? "R4" : "R3", "done latency", waits, 0);
      chk(fires == 0, bad ? "R4" : "R3", "command count", fires, 0);
    end else begin
      chk(cyc == last_fire_cyc, "R10", "done one cycle after last command", cyc, last_fire_cyc);
    end
    exp_q.delete();
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", "run hung", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
        {req_ready, cmd_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1", "after reset",
        {req_ready, cmd_valid, done}, 3'b100);
    run_mon = 1'b1;

    // R2 alignment and end-exclusive counts, packed style
    run_req(32'h0000_1000, 16'd64, 1'b0, 32'h0, 1'b0, 3'd0, "R2");
    run_req(32'h0000_1005, 16'd59, 1'b0, 32'h0, 1'b0, 3'd1, "R2");
    run_req(32'h0000_1005, 16'd60, 1'b0, 32'h0, 1'b0, 3'd1, "R2");
    // R5 alias enumeration, with back-pressure (R9)
    bp_on = 1'b1;
    run_req(32'h0000_2010, 16'd40, 1'b0, 32'h0, 1'b0, 3'd2, "R5");
    run_req(32'h0000_4000, 16'd32, 1'b0, 32'h0, 1'b0, 3'd4, "R5");
    // R6 packed virtual bits
    run_req(32'h0000_8020, 16'd70, 1'b1, 32'h0003_6000, 1'b0, 3'd4, "R6");
    // R7 split style
    run_req(32'h0002_3040, 16'd33, 1'b0, 32'h0, 1'b1, 3'd2, "R7");
    bp_on = 1'b0;
    run_req(32'h0001_E000, 16'd20, 1'b0, 32'h0, 1'b1, 3'd4, "R7");
    run_req(32'h0001_E000, 16'd64, 1'b0, 32'h0, 1'b1, 3'd0, "R7");
    // R8 split style with virtual index
    bp_on = 1'b1;
    run_req(32'h0003_0030, 16'd100, 1'b1, 32'h0007_1234, 1'b1, 3'd4, "R8");
    bp_on = 1'b0;
    // R3 zero size, R4 bad ratios
    run_req(32'h0000_5000, 16'd0, 1'b0, 32'h0, 1'b0, 3'd2, "R3");
    run_req(32'h0000_5000, 16'd64, 1'b0, 32'h0, 1'b0, 3'd3, "R4");
    run_req(32'h0000_5000, 16'd64, 1'b0, 32'h0, 1'b1, 3'd6, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule